// File: doc/BRIEF.md
# Branch Outcome Log and Replay Comparator

This block keeps a log of how every control instruction resolved during the first, normal run of a checkpoint interval. Each entry holds the taken bit and the target address. When the rollback controller rewinds to the newest checkpoint and starts a re-execution pass, the block plays the logged outcomes back in program order as predictions. The replay therefore does not mispredict. The block also checks each outcome the replay resolves against the logged one.

If a replayed outcome disagrees with the log, the block declares a soft error. It pulses an error event, increments a saturating error counter that a threshold-tuning policy can read, and raises a request for a third run of the interval. During that third run, the outcome at the disputed position is compared with both the original and the replayed outcome, and the block reports which of the two runs was faulty.

The log is a circular buffer shared by two live checkpoint intervals. It keeps one base pointer for the older interval and one for the newer. Discarding the older checkpoint frees its entries. If an interval runs out of space, logging stops for the rest of that interval, and replay and comparison then cover only the entries that were logged.

Top module: `br_outcome_log`

## Requirements
- R1: In record mode (mode_i = 1), every cycle with br_valid_i high appends {br_taken_i, br_target_i} to the log, unless the interval has overflowed (see R7).
- R2: A pass_start_i pulse in replay mode (2) or third-run mode (3) rewinds to the newest checkpoint. While logged entries remain, pred_valid_o is high and pred_taken_o/pred_target_o show the next entry in recorded order. Each resolve moves to the next entry. Once the entries run out, pred_valid_o is low. pred_valid_o is never high in record or idle mode.
- R3: In replay mode, a resolve differs from its logged entry when the taken bits differ, or when both are taken and the targets differ. The target of a not-taken outcome is ignored. The first differing resolve of a pass makes err_o high for exactly the cycle after that resolve edge. Later differences in the same pass raise no further error.
- R4: err_cnt_o resets to 0 and increments by one in the same cycle err_o is high, saturating at all ones. It holds its value otherwise.
- R5: third_req_o rises together with err_o and stays high until a pass_start_i pulse in third-run mode.
- R6: In a third-run pass, the resolve at the disputed log position produces a one-cycle verdict_valid_o in the following cycle. verdict_o is 1 if the third outcome matches the replay (original run faulty), 2 if it matches the original (replay faulty), and 3 if it matches neither.
- R7: Log occupancy is measured from the older checkpoint base to the write point, and capacity is DEPTH entries. A record attempt while the log is full is dropped, and all further records of that interval are dropped until the next ckpt_i. Replay offers no prediction beyond the last logged entry and compares nothing there.
- R8: ckpt_i sets the newer base to the write point and starts a new interval. free_i discards the older checkpoint by moving the older base to the newer base, which releases its entries for new records.
- R9: After reset: pred_valid_o, err_o, third_req_o and verdict_valid_o are 0, and err_cnt_o is 0.
- R10: In idle mode (0), resolves are neither logged nor compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 idle, 1 record, 2 replay, 3 third run |
| ckpt_i | input | 1 | New checkpoint taken: a new interval starts |
| free_i | input | 1 | Older checkpoint discarded |
| pass_start_i | input | 1 | Start of a replay or third-run pass |
| br_valid_i | input | 1 | A control instruction resolved this cycle |
| br_taken_i | input | 1 | Resolved direction |
| br_target_i | input | TGT_W | Resolved target address |
| pred_valid_o | output | 1 | A logged prediction is offered |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | TGT_W | Predicted target |
| err_o | output | 1 | Soft error declared (one-cycle pulse) |
| err_cnt_o | output | CNT_W | Saturating count of declared errors |
| third_req_o | output | 1 | Third execution requested |
| verdict_valid_o | output | 1 | Third-run verdict available |
| verdict_o | output | 2 | 1 original faulty, 2 replay faulty, 3 unresolved |

## Verification
The bound checker examines every cycle for the properties that need no knowledge of log contents. These are: the error event lasts a single cycle, the counter steps only with that event and otherwise holds, the third-run request never rises without an error, verdicts appear only after third-run cycles and never carry code 0, and no prediction is offered while recording or idle. Which entry is predicted, whether a given difference counts as an error, the verdict chosen, and how overflow and freeing change what replay sees all depend on the history stored in the log. Only the bench's record-then-replay scenarios can show those.

// File: rtl/blog_pkg.sv
package blog_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_RECORD = 2'd1,
    MODE_REPLAY = 2'd2,
    MODE_THIRD  = 2'd3
  } blog_mode_e;

  typedef enum logic [1:0] {
    VERD_NONE       = 2'd0,
    VERD_ORIG_BAD   = 2'd1,
    VERD_REPLAY_BAD = 2'd2,
    VERD_UNRESOLVED = 2'd3
  } blog_verdict_e;
endpackage

// File: rtl/blog_mem.sv
module blog_mem #(
  parameter int ENT_W = 33,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [ENT_W-1:0] rd_data_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/blog_ptrs.sv
module blog_ptrs
  import blog_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  blog_mode_e    mode_i,
  input  logic          br_valid_i,
  input  logic          ckpt_i,
  input  logic          free_i,
  input  logic          pass_start_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          rd_live_o
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] wr_q, old_q, new_q, rd_q, end_q;
  logic          ovf_q;
  logic          rec, full, replay_mode;

  assign replay_mode = (mode_i == MODE_REPLAY) || (mode_i == MODE_THIRD);
  assign rec         = (mode_i == MODE_RECORD) && br_valid_i;
  assign full        = (wr_q - old_q) == CAP;
  assign wr_en_o     = rec && !ovf_q && !full;
  assign wr_idx_o    = wr_q[IW-1:0];
  assign rd_idx_o    = rd_q[IW-1:0];
  assign rd_ptr_o    = rd_q;
  assign rd_live_o   = rd_q != end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      old_q <= '0;
      new_q <= '0;
      rd_q  <= '0;
      end_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (ckpt_i) new_q <= wr_q;
      if (free_i) old_q <= new_q;
      if (ckpt_i) ovf_q <= 1'b0;
      else if (rec && !wr_en_o) ovf_q <= 1'b1;  // stop logging for the rest of interval
      if (wr_en_o) wr_q <= wr_q + PW'(1);
      if (pass_start_i && replay_mode) begin
        rd_q  <= new_q;
        end_q <= wr_q;
      end else if (replay_mode && br_valid_i && rd_live_o) begin
        rd_q <= rd_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/blog_judge.sv
module blog_judge
  import blog_pkg::*;
#(
  parameter int TGT_W = 32,
  parameter int PW    = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  blog_mode_e       mode_i,
  input  logic             pass_start_i,
  input  logic             br_valid_i,
  input  logic             br_taken_i,
  input  logic [TGT_W-1:0] br_target_i,
  input  logic             rd_live_i,
  input  logic [PW-1:0]    rd_ptr_i,
  input  logic             log_taken_i,
  input  logic [TGT_W-1:0] log_target_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [TGT_W-1:0] pred_target_o,
  output logic             err_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             third_req_o,
  output logic             verdict_valid_o,
  output blog_verdict_e    verdict_o
);
  function automatic logic differs(logic a_t, logic [TGT_W-1:0] a_g,
                                   logic b_t, logic [TGT_W-1:0] b_g);
    return (a_t != b_t) || (a_t && (a_g != b_g));
  endfunction

  logic             replay_mode, cmp, mis;
  logic             seen_q, cap_valid_q, cap_taken_q;
  logic [PW-1:0]    cap_idx_q;
  logic [TGT_W-1:0] cap_target_q;
  logic [CNT_W-1:0] cnt_q;

  assign replay_mode   = (mode_i == MODE_REPLAY) || (mode_i == MODE_THIRD);
  assign pred_valid_o  = replay_mode && rd_live_i;
  assign pred_taken_o  = log_taken_i;
  assign pred_target_o = log_target_i;
  assign cmp           = replay_mode && br_valid_i && rd_live_i;
  assign mis           = cmp && differs(br_taken_i, br_target_i, log_taken_i, log_target_i);
  assign err_cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q          <= 1'b0;
      cap_valid_q     <= 1'b0;
      cap_taken_q     <= 1'b0;
      cap_idx_q       <= '0;
      cap_target_q    <= '0;
      cnt_q           <= '0;
      err_o           <= 1'b0;
      third_req_o     <= 1'b0;
      verdict_valid_o <= 1'b0;
      verdict_o       <= VERD_NONE;
    end else begin
      err_o           <= 1'b0;
      verdict_valid_o <= 1'b0;
      if (pass_start_i && mode_i == MODE_REPLAY) begin
        seen_q      <= 1'b0;
        cap_valid_q <= 1'b0;
      end else if (pass_start_i && mode_i == MODE_THIRD) begin
        third_req_o <= 1'b0;
      end else if (mis && mode_i == MODE_REPLAY && !seen_q) begin
        err_o        <= 1'b1;
        seen_q       <= 1'b1;
        cap_valid_q  <= 1'b1;
        cap_idx_q    <= rd_ptr_i;
        cap_taken_q  <= br_taken_i;
        cap_target_q <= br_target_i;
        third_req_o  <= 1'b1;
        if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
      end else if (cmp && mode_i == MODE_THIRD && cap_valid_q && rd_ptr_i == cap_idx_q) begin
        verdict_valid_o <= 1'b1;
        if (!differs(br_taken_i, br_target_i, cap_taken_q, cap_target_q))
          verdict_o <= VERD_ORIG_BAD;
        else if (!differs(br_taken_i, br_target_i, log_taken_i, log_target_i))
          verdict_o <= VERD_REPLAY_BAD;
        else
          verdict_o <= VERD_UNRESOLVED;
      end
    end
  end
endmodule

// File: rtl/br_outcome_log.sv
module br_outcome_log
  import blog_pkg::*;
#(
  parameter int TGT_W = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ckpt_i,
  input  logic             free_i,
  input  logic             pass_start_i,
  input  logic             br_valid_i,
  input  logic             br_taken_i,
  input  logic [TGT_W-1:0] br_target_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [TGT_W-1:0] pred_target_o,
  output logic             err_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             third_req_o,
  output logic             verdict_valid_o,
  output logic [1:0]       verdict_o
);
  localparam int ENT_W = TGT_W + 1;
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = IW + 1;

  blog_mode_e    mode;
  blog_verdict_e verdict;
  logic             wr_en, rd_live;
  logic [IW-1:0]    wr_idx, rd_idx;
  logic [PW-1:0]    rd_ptr;
  logic [ENT_W-1:0] rd_data;

  assign mode      = blog_mode_e'(mode_i);
  assign verdict_o = verdict;

  blog_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni, .mode_i(mode), .br_valid_i, .ckpt_i, .free_i, .pass_start_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .rd_ptr_o(rd_ptr),
    .rd_live_o(rd_live)
  );

  blog_mem #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i({br_taken_i, br_target_i}),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  blog_judge #(.TGT_W(TGT_W), .PW(PW), .CNT_W(CNT_W)) u_judge (
    .clk_i, .rst_ni, .mode_i(mode), .pass_start_i, .br_valid_i, .br_taken_i, .br_target_i,
    .rd_live_i(rd_live), .rd_ptr_i(rd_ptr),
    .log_taken_i(rd_data[ENT_W-1]), .log_target_i(rd_data[TGT_W-1:0]),
    .pred_valid_o, .pred_taken_o, .pred_target_o, .err_o, .err_cnt_o, .third_req_o,
    .verdict_valid_o, .verdict_o(verdict)
  );
endmodule

// File: rtl/br_outcome_log_chk.sv
module br_outcome_log_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             pred_valid_o,
  input logic             err_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             third_req_o,
  input logic             verdict_valid_o,
  input logic [1:0]       verdict_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_err_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(err_cnt_o) != CMAX) |-> err_cnt_o == $past(err_cnt_o) + CNT_W'(1));

  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> $stable(err_cnt_o));

  p_third_req_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(third_req_o) |-> err_o);

  p_verdict_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> verdict_o != 2'd0);

  p_verdict_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> $past(mode_i) == 2'd3);

  p_no_pred_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 || mode_i == 2'd0) |-> !pred_valid_o);
endmodule

bind br_outcome_log br_outcome_log_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pred_valid_o(pred_valid_o),
  .err_o(err_o), .err_cnt_o(err_cnt_o), .third_req_o(third_req_o),
  .verdict_valid_o(verdict_valid_o), .verdict_o(verdict_o)
);

// File: tb/tb_br_outcome_log.sv
module tb_br_outcome_log;
  localparam int TGT_W = 16;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int NV    = 6;
  // {rec_taken, rec_target, rep_taken, rep_target, exp_err}
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 16'h0100, 1'b1, 16'h0100, 1'b0},
    {1'b0, 16'h0110, 1'b0, 16'h0999, 1'b0},  // not-taken target ignored
    {1'b1, 16'h0200, 1'b1, 16'h0200, 1'b0},
    {1'b1, 16'h0300, 1'b0, 16'h0300, 1'b1},  // direction flip
    {1'b1, 16'h0400, 1'b1, 16'h0444, 1'b0},  // second difference, no new error
    {1'b0, 16'h0500, 1'b0, 16'h0500, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ckpt = 0, free_p = 0, pstart = 0, bv = 0, bt = 0;
  logic [TGT_W-1:0] bg = '0;
  logic pv, pt, err, treq, vv;
  logic [TGT_W-1:0] pg;
  logic [CNT_W-1:0] cnt;
  logic [1:0] verd;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  br_outcome_log #(.TGT_W(TGT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ckpt_i(ckpt), .free_i(free_p),
    .pass_start_i(pstart), .br_valid_i(bv), .br_taken_i(bt), .br_target_i(bg),
    .pred_valid_o(pv), .pred_taken_o(pt), .pred_target_o(pg), .err_o(err),
    .err_cnt_o(cnt), .third_req_o(treq), .verdict_valid_o(vv), .verdict_o(verd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ckpt(); ckpt = 1; @(negedge clk); ckpt = 0; endtask
  task automatic pulse_free(); free_p = 1; @(negedge clk); free_p = 0; endtask
  task automatic start_pass(input logic [1:0] m);
    mode = m; pstart = 1; @(negedge clk); pstart = 0;
  endtask
  task automatic resolve(input logic t, input logic [TGT_W-1:0] g);
    bv = 1; bt = t; bg = g; @(negedge clk); bv = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int npred;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(pv == 0 && err == 0 && treq == 0 && vv == 0, "R9 outputs", {pv, err, treq, vv}, 0);
    chk(cnt == 0, "R9 counter", cnt, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 record table
    mode = 2'd1;
    pulse_ckpt();
    for (int i = 0; i < NV; i++) begin
      chk(pv == 0, "R2 no prediction while recording", pv, 0);
      resolve(VEC[i][34], VEC[i][33:18]);
    end

    // R2/R3 replay walk
    start_pass(2'd2);
    for (int i = 0; i < NV; i++) begin
      chk(pv == 1 && pt == VEC[i][34] && pg == VEC[i][33:18], "R1 R2 logged prediction",
          {pv, pt, pg}, {1'b1, VEC[i][34], VEC[i][33:18]});
      resolve(VEC[i][17], VEC[i][16:1]);
      chk(err == VEC[i][0], "R3 error pulse", err, VEC[i][0]);
    end
    chk(pv == 0, "R2 prediction ends after last entry", pv, 0);
    chk(cnt == 1, "R4 counter after one error", cnt, 1);
    chk(treq == 1, "R5 third run requested", treq, 1);

    // R6 three verdict cases
    for (int k = 0; k < 3; k++) begin
      start_pass(2'd3);
      chk(treq == 0, "R5 request cleared by third pass", treq, 0);
      for (int i = 0; i < 3; i++) begin
        resolve(VEC[i][34], VEC[i][33:18]);
        chk(vv == 0, "R6 no verdict off the disputed entry", vv, 0);
      end
      if (k == 0) resolve(1'b0, 16'h0300);
      else if (k == 1) resolve(1'b1, 16'h0300);
      else resolve(1'b1, 16'h0333);
      chk(vv == 1 && verd == 2'(k + 1), "R6 verdict", {vv, verd}, {1'b1, 2'(k + 1)});
      @(negedge clk);
      chk(vv == 0, "R6 verdict one cycle", vv, 0);
    end

    // R10 idle resolves ignored
    mode = 2'd0;
    resolve(1'b1, 16'hDEAD);
    chk(err == 0 && pv == 0, "R10 idle no compare", {err, pv}, 0);
    start_pass(2'd2);
    npred = 0;
    for (int i = 0; i < NV + 2; i++) begin
      if (pv) begin npred++; resolve(pt, pg); end
    end
    chk(npred == NV, "R10 idle resolve not logged", npred, NV);
    chk(cnt == 1 && err == 0, "R3 matching replay no error", cnt, 1);

    // R7 overflow: interval at base 6, freed older entries
    mode = 2'd1;
    pulse_ckpt();
    pulse_free();
    for (int i = 0; i < 10; i++) resolve(1'b1, 16'h1000 + 16'(i));
    start_pass(2'd2);
    for (int i = 0; i < DEPTH; i++) begin
      chk(pv == 1 && pg == 16'h1000 + 16'(i), "R7 logged part replayed", {pv, pg},
          {1'b1, 16'h1000 + 16'(i)});
      resolve(1'b1, 16'h1000 + 16'(i));
    end
    chk(pv == 0, "R7 no prediction past overflow", pv, 0);
    resolve(1'b0, 16'h0000);
    chk(err == 0 && cnt == 1, "R7 no compare past overflow", {err, cnt}, 1);

    // R8 full log until older checkpoint freed
    mode = 2'd1;
    pulse_ckpt();
    resolve(1'b1, 16'hAAAA);
    start_pass(2'd2);
    chk(pv == 0, "R8 record dropped while older entries held", pv, 0);
    mode = 2'd1;
    pulse_free();
    pulse_ckpt();
    resolve(1'b1, 16'hBBBB);
    start_pass(2'd2);
    chk(pv == 1 && pg == 16'hBBBB, "R8 record after free", {pv, pg}, {1'b1, 16'hBBBB});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule